// File: doc/BRIEF.md
# DDR SDRAM Refresh and Self-Refresh Sequencer

This block sits beside the main memory controller and keeps a double-data-rate SDRAM refreshed. An interval timer marks when each auto refresh falls due. Refreshes that are due but not yet issued are counted. While any are pending, the block raises an idle request. The controller keeps issuing its own commands until it has closed every bank, and then it acknowledges. Once it has the acknowledgement, the block takes the command bus and issues every pending refresh back to back. Each refresh is followed by its recovery wait. After that, control returns to the controller. Up to a fixed number of refreshes may be postponed this way. When that limit is reached, an urgent flag tells the controller it must yield at once.

A self-refresh request follows the same idle handshake. The block presents the refresh encoding with the clock-enable low and keeps the clock-enable low while the request stays high. When the request drops, the block drives the clock-enable high with a deselect. It then counts the exit wait for non-read commands and issues one auto refresh. After that refresh's recovery wait, it hands the bus back. Read commands stay blocked until a separate, longer exit window has passed. The interval timer is frozen while the clock-enable is low.

Top module: `ddr_refresh_seq`

## Requirements
- R1: After reset the pins show a no-operation (cs_no=0, ras_no=1, cas_no=1, we_no=1) with cke_o=1. Also after reset cmd_ok_o=1, read_ok_o=1, busy_o=0, idle_req_o=0 and urgent_o=0.
- R2: A refresh falls due every CLK_PER_REF cycles. The default is 64 ms / 8192 = 7.8 µs at the 50 MHz clock, which is 390 cycles. When idle_ack_i is held high, every window of 8*CLK_PER_REF cycles contains exactly 8 auto refreshes, and the first one appears CLK_PER_REF+1 cycles after reset is released.
- R3: An auto refresh is issued only after idle_ack_i is seen high while idle_req_o is high. While idle_ack_i stays low, no auto refresh appears.
- R4: An auto refresh is one cycle with cs_no=0, ras_no=0, cas_no=0, we_no=1 and cke_o=1.
- R5: The first cycle after an auto refresh that can carry another command, or cmd_ok_o=1, is exactly T_REF_CYC cycles after that refresh. cmd_ok_o is 0 in between.
- R6: idle_req_o is high while one or more refreshes are pending. urgent_o rises when MAX_PENDING are pending and not before. The pending count saturates there. After the acknowledgement, exactly the pending number of refreshes is issued back to back.
- R7: Self-refresh entry is one cycle with cs_no=0, ras_no=0, cas_no=0, we_no=1 and cke_o=0. After it, cke_o stays low with deselect (cs_no=1) for as long as sr_req_i is held high.
- R8: In the cycle after sr_req_i falls, the pins show cke_o=1 with cs_no=1. No refresh falls due while cke_o is low.
- R9: The first auto refresh after self-refresh exit appears exactly T_XSNR_CYC cycles after the exit cycle.
- R10: read_ok_o first rises exactly T_XSRD_CYC cycles after the exit cycle. read_ok_o is never high while cmd_ok_o is low.
- R11: After self-refresh exit, at least one auto refresh is issued before cmd_ok_o returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sr_req_i | input | 1 | Request to enter, and stay in, self refresh |
| idle_ack_i | input | 1 | Controller reports all banks closed and the bus free |
| idle_req_o | output | 1 | Asks the controller to close all banks |
| urgent_o | output | 1 | Postponement limit reached; the controller must yield |
| busy_o | output | 1 | The sequencer owns the command bus |
| cmd_ok_o | output | 1 | Controller may issue non-read commands |
| read_ok_o | output | 1 | Controller may issue read commands |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable |

## Verification
The hardest state to reach is the saturated pending count. It appears only when the controller refuses the idle handshake for more than MAX_PENDING refresh intervals. The bench holds idle_ack_i low from reset through ten intervals. It samples urgent_o just before and after the eighth interval, and then acknowledges at a point where no further interval falls within the burst. That lets it count the burst exactly: eight refreshes, not ten. The self-refresh exit windows are reached by holding sr_req_i for several intervals after entry. The bench then times the refresh, cmd_ok_o and read_ok_o against the exit cycle.

// File: rtl/ref_seq_pkg.sv
package ref_seq_pkg;

  typedef enum logic [2:0] {
    ST_RUN, ST_REF, ST_TREF, ST_SR_ENTER, ST_SR, ST_SR_EXIT, ST_XSNR
  } seq_st_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic cke;
  } pins_t;

  localparam pins_t PINS_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, cke: 1'b1};
  localparam pins_t PINS_AREF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, cke: 1'b1};
  localparam pins_t PINS_SRIN  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, cke: 1'b0};
  localparam pins_t PINS_SRHLD = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, cke: 1'b0};
  localparam pins_t PINS_SROUT = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, cke: 1'b1};

  function automatic pins_t pins_for(seq_st_e st);
    case (st)
      ST_REF:      return PINS_AREF;
      ST_SR_ENTER: return PINS_SRIN;
      ST_SR:       return PINS_SRHLD;
      ST_SR_EXIT:  return PINS_SROUT;
      default:     return PINS_NOP;
    endcase
  endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned PERIOD = 390
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pause_i,
  output logic tick_o
);
  localparam int unsigned CW = (PERIOD < 2) ? 1 : $clog2(PERIOD);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(PERIOD - 1));
  assign tick_o = wrap && !pause_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!pause_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  AST_PAUSE_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/ref_pending_cnt.sv
module ref_pending_cnt #(
  parameter int unsigned MAX_PENDING = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic dec_i,
  output logic pend_o,
  output logic full_o
);
  localparam int unsigned PW = $clog2(MAX_PENDING + 1);

  logic [PW-1:0] cnt_q;
  logic          inc, dec;

  assign pend_o = (cnt_q != '0);
  assign full_o = (cnt_q == PW'(MAX_PENDING));
  assign inc    = tick_i && !full_o;
  assign dec    = dec_i && pend_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (inc && !dec) cnt_q <= cnt_q + 1'b1;
    else if (dec && !inc) cnt_q <= cnt_q - 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && tick_i && !dec_i) |=> full_o); // R6
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q <= PW'(MAX_PENDING))); // R6

endmodule

// File: rtl/ref_wait_cnt.sv
module ref_wait_cnt #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= val_i;
    else if (!zero_o) cnt_q <= cnt_q - 1'b1;
  end

  AST_COUNTS_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5

endmodule

// File: rtl/ddr_refresh_seq.sv
module ddr_refresh_seq
  import ref_seq_pkg::*;
#(
  parameter int unsigned WINDOW_US    = 64000,
  parameter int unsigned REFS_PER_WIN = 8192,
  parameter int unsigned CLK_MHZ      = 50,
  parameter int unsigned CLK_PER_REF  = WINDOW_US * CLK_MHZ / REFS_PER_WIN,
  parameter int unsigned MAX_PENDING  = 8,
  parameter int unsigned T_REF_CYC    = 4,
  parameter int unsigned T_XSNR_CYC   = 6,
  parameter int unsigned T_XSRD_CYC   = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sr_req_i,
  input  logic idle_ack_i,
  output logic idle_req_o,
  output logic urgent_o,
  output logic busy_o,
  output logic cmd_ok_o,
  output logic read_ok_o,
  output logic cs_no,
  output logic ras_no,
  output logic cas_no,
  output logic we_no,
  output logic cke_o
);
  localparam int unsigned T_MAX  = (T_XSRD_CYC > T_XSNR_CYC) ?
                                   ((T_XSRD_CYC > T_REF_CYC) ? T_XSRD_CYC : T_REF_CYC) :
                                   ((T_XSNR_CYC > T_REF_CYC) ? T_XSNR_CYC : T_REF_CYC);
  localparam int unsigned WAIT_W = $clog2(T_MAX + 1);

  seq_st_e st_q, st_d;
  pins_t   pins;
  logic    tick, pend, full, gap_zero, rd_zero;
  logic    gap_load, rd_load;
  logic [WAIT_W-1:0] gap_val;

  ref_interval_timer #(.PERIOD(CLK_PER_REF)) i_timer (
    .clk_i, .rst_ni,
    .pause_i(!pins.cke),
    .tick_o (tick)
  );

  ref_pending_cnt #(.MAX_PENDING(MAX_PENDING)) i_pending (
    .clk_i, .rst_ni,
    .tick_i(tick),
    .dec_i (st_q == ST_REF),
    .pend_o(pend),
    .full_o(full)
  );

  // Recovery gap after refresh and non-read exit gap share one counter
  assign gap_load = (st_q == ST_REF) || (st_q == ST_SR_EXIT);
  assign gap_val  = (st_q == ST_REF) ? WAIT_W'(T_REF_CYC - 2) : WAIT_W'(T_XSNR_CYC - 2);

  ref_wait_cnt #(.W(WAIT_W)) i_gap (
    .clk_i, .rst_ni,
    .load_i(gap_load),
    .val_i (gap_val),
    .zero_o(gap_zero)
  );

  assign rd_load = (st_q == ST_SR_EXIT);

  ref_wait_cnt #(.W(WAIT_W)) i_rdgap (
    .clk_i, .rst_ni,
    .load_i(rd_load),
    .val_i (WAIT_W'(T_XSRD_CYC - 1)),
    .zero_o(rd_zero)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RUN:
        if (idle_ack_i && pend)          st_d = ST_REF;
        else if (idle_ack_i && sr_req_i) st_d = ST_SR_ENTER;
      ST_REF:      st_d = ST_TREF;
      ST_TREF:
        if (gap_zero) begin
          if (pend)          st_d = ST_REF;
          else if (sr_req_i) st_d = ST_SR_ENTER;
          else               st_d = ST_RUN;
        end
      ST_SR_ENTER: st_d = ST_SR;
      ST_SR:       if (!sr_req_i) st_d = ST_SR_EXIT;
      ST_SR_EXIT:  st_d = ST_XSNR;
      ST_XSNR:     if (gap_zero) st_d = ST_REF;
      default:     st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end

  assign pins       = pins_for(st_q);
  assign cs_no      = pins.cs_n;
  assign ras_no     = pins.ras_n;
  assign cas_no     = pins.cas_n;
  assign we_no      = pins.we_n;
  assign cke_o      = pins.cke;
  assign busy_o     = (st_q != ST_RUN);
  assign cmd_ok_o   = (st_q == ST_RUN);
  assign read_ok_o  = cmd_ok_o && rd_zero;
  assign idle_req_o = cmd_ok_o && (pend || sr_req_i);
  assign urgent_o   = full;

  initial begin
    AST_PARAM_GAPS: assert (T_REF_CYC >= 2 && T_XSNR_CYC >= 2 && T_XSRD_CYC >= 1); // R5
  end

  AST_AREF_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_REF && $past(st_q) == ST_RUN) |-> $past(idle_ack_i && idle_req_o)); // R3
  AST_AREF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !ras_no && !cas_no && cke_o) |=> (!cmd_ok_o && cs_no == 1'b0 && ras_no)); // R5
  AST_SR_ENTRY_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> (!cs_no && !ras_no && !cas_no && we_no)); // R7
  AST_SR_EXIT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> cs_no); // R8
  AST_SR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && sr_req_i) |=> !cke_o); // R7
  AST_READ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_ok_o |-> cmd_ok_o); // R10

endmodule

// File: tb/test_ddr_refresh_seq.sv
module test_ddr_refresh_seq;
  localparam int P     = 40;
  localparam int MAXP  = 8;
  localparam int TREF  = 4;
  localparam int TXSNR = 6;
  localparam int TXSRD = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sr_req = 1'b0;
  logic ack = 1'b0;
  logic idle_req, urgent, busy, cmd_ok, read_ok, cs_n, ras_n, cas_n, we_n, cke;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int ar_total = 0;
  int ar_last = -100;
  bit done = 0;

  always #10 clk = ~clk;

  ddr_refresh_seq #(
    .CLK_PER_REF(P), .MAX_PENDING(MAXP),
    .T_REF_CYC(TREF), .T_XSNR_CYC(TXSNR), .T_XSRD_CYC(TXSRD)
  ) i_ddr_refresh_seq (
    .clk_i(clk), .rst_ni(rst_ni), .sr_req_i(sr_req), .idle_ack_i(ack),
    .idle_req_o(idle_req), .urgent_o(urgent), .busy_o(busy),
    .cmd_ok_o(cmd_ok), .read_ok_o(read_ok),
    .cs_no(cs_n), .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n), .cke_o(cke)
  );

  function automatic bit is_aref();
    return !cs_n && !ras_n && !cas_n && we_n && cke;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (is_aref()) begin
      ar_total++;
      ar_last = cyc;
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    sr_req = 1'b0;
    ack    = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni   = 1'b1;
    cyc      = 0;
    ar_total = 0;
    ar_last  = -100;
  endtask

  task automatic t_reset();
    do_reset();
    step();
    chk("R1 pins", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk("R1 cke", cke, 1);
    chk("R1 cmd_ok", cmd_ok, 1);
    chk("R1 read_ok", read_ok, 1);
    chk("R1 busy", busy, 0);
    chk("R1 idle_req", idle_req, 0);
    chk("R1 urgent", urgent, 0);
  endtask

  task automatic t_interval();
    int n0;
    int bad_gap;
    do_reset();
    ack = 1'b1;
    while (ar_total == 0 && cyc < 200) step();
    chk("R2 first refresh cycle", ar_last, P + 1);
    chk("R4 refresh encoding", {cs_n, ras_n, cas_n, we_n, cke}, 5'b00011);
    n0 = ar_total;
    bad_gap = 0;
    for (int i = 0; i < 8 * P; i++) begin
      step();
      if (cyc == ar_last + TREF - 1 && cmd_ok) bad_gap++;
      if (cyc == ar_last + TREF && !cmd_ok) bad_gap++;
      if (cyc == ar_last + 1 && !(cs_n == 1'b0 && ras_n && cas_n && we_n)) bad_gap++;
    end
    chk("R2 refreshes per window", ar_total - n0, 8);
    chk("R5 recovery gap violations", bad_gap, 0);
  endtask

  task automatic t_postpone();
    int a0;
    int spacing_bad;
    int ok_at;
    do_reset();
    while (cyc < 7 * P + P / 2) step();
    chk("R6 idle_req with pending", idle_req, 1);
    chk("R6 urgent below limit", urgent, 0);
    chk("R6 cmd_ok while postponed", cmd_ok, 1);
    while (cyc < 8 * P + P / 2) step();
    chk("R6 urgent at limit", urgent, 1);
    while (cyc < 10 * P + 2) step();
    chk("R3 no refresh without ack", ar_total, 0);
    chk("R6 urgent after saturation", urgent, 1);
    ack = 1'b1;
    step();
    chk("R3 refresh right after ack", ar_last, 10 * P + 3);
    a0 = ar_last;
    spacing_bad = 0;
    ok_at = -1;
    for (int i = 0; i < 60 && ok_at < 0; i++) begin
      step();
      if (is_aref() && (cyc - a0) % TREF != 0) spacing_bad++;
      if (cmd_ok) ok_at = cyc;
    end
    chk("R6 burst count after ack", ar_total, MAXP);
    chk("R6 back-to-back spacing", spacing_bad, 0);
    chk("R5 handback after last refresh", ok_at, ar_last + TREF);
    chk("R6 urgent cleared", urgent, 0);
  endtask

  task automatic t_self_refresh();
    int e;
    int low_bad;
    int first_ar;
    int ar_before_ok;
    int ok_at;
    int rd_at;
    int n0;
    do_reset();
    ack = 1'b1;
    while (ar_total == 0) step();
    repeat (TREF + 2) step();
    sr_req = 1'b1;
    for (int i = 0; i < 50 && cke; i++) step();
    chk("R7 entry encoding", {cs_n, ras_n, cas_n, we_n, cke}, 5'b00010);
    low_bad = 0;
    for (int i = 0; i < 5 * P; i++) begin
      step();
      if (cke || !cs_n) low_bad++;
    end
    chk("R7 cke low with deselect", low_bad, 0);
    chk("R7 busy during self refresh", busy, 1);
    sr_req = 1'b0;
    step();
    e = cyc;
    chk("R8 exit cke", cke, 1);
    chk("R8 exit deselect", cs_n, 1);
    n0 = ar_total;
    first_ar = -1;
    ar_before_ok = 0;
    ok_at = -1;
    rd_at = -1;
    for (int i = 0; i < 60 && rd_at < 0; i++) begin
      step();
      if (is_aref() && first_ar < 0) first_ar = cyc;
      if (cmd_ok && ok_at < 0) begin
        ok_at = cyc;
        ar_before_ok = ar_total - n0;
      end
      if (read_ok && rd_at < 0) rd_at = cyc;
    end
    chk("R9 first refresh after exit", first_ar - e, TXSNR);
    chk("R10 read window", rd_at - e, TXSRD);
    chk("R11 refresh before handback", (ar_before_ok >= 1) ? 1 : 0, 1);
    chk("R8 timer paused (refreshes before handback <= 2)", (ar_before_ok <= 2) ? 1 : 0, 1);
    chk("R11 handback not before refresh gap", (ok_at >= e + TXSNR + TREF) ? 1 : 0, 1);
  endtask

  initial begin
    t_reset();
    t_interval();
    t_postpone();
    t_self_refresh();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule